// File: doc/BRIEF.md
# Sync-Triggered Clamp Pulse Generator

This block makes the gating pulse for a video input clamp. It works from one of two timing lines: a horizontal sync input or a blanking (flyback) input. Both inputs are brought into the sampling clock domain. The sync input is corrected to positive polarity automatically. The blanking input goes through an inverter that software can switch in or out. The chosen edge of the chosen source then starts a pulse of programmable length.

A direct mode skips all of this processing. In that mode an externally made clamp pulse on the sync input goes straight to the output. The polarity-corrected blanking signal is also brought out, so the downstream blanking logic can use it. A configuration bit that picks the source for the output-stage clamp is passed through as well.

Two 8-bit control words are presented as parallel inputs. Their decode is fixed as follows:
- `cfg_main[0]`: trigger source.
- `cfg_main[1]`: trigger edge.
- `cfg_main[3:2]`: width code.
- `cfg_main[4]`: direct mode.
- `cfg_main[7]`: output-clamp source.
- `cfg_aux[0]`: blanking inversion.

All other bits are ignored.

Top module: `clamp_pulse_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `clamp_pulse` is 0 and `blank_pos` equals `cfg_aux[0]`. With all control bits at zero, the block uses the sync source, the leading edge, the shortest width and no blanking inversion.
- R2: `cfg_main[0]` = 0 triggers the pulse from the polarity-corrected sync. A value of 1 triggers it from `blank_pos`.
- R3: Sync of either polarity gives the same pulse timing once the detector has settled. The detector runs at every rising edge of the synchronised raw sync. At that point it compares the high and low sample counts of the line just ended. The sync is treated as active-low when it spent more samples high.
- R4: `cfg_main[1]` = 0 selects the leading (rising, after correction) edge and 1 selects the trailing edge. An input transition captured at clock edge k makes `clamp_pulse` high from edge k+2.
- R5: `cfg_main[3:2]` codes 0, 1, 2 and 3 give pulses of 8, 16, 32 and 64 clock cycles.
- R6: A trigger that arrives while a pulse is active restarts the full width from that trigger.
- R7: `blank_pos` is the blanking input delayed by two clock edges. It is XORed with `cfg_aux[0]`, so 1 inverts it.
- R8: With `cfg_main[4]` = 1, `clamp_pulse` equals the raw sync input delayed by two edges. No polarity correction is applied, and the edge and width fields have no effect.
- R9: `out_clamp_sel` follows `cfg_main[7]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Horizontal sync, either polarity |
| blank_in | input | 1 | Blanking / flyback line |
| cfg_main | input | 8 | Main control word (source, edge, width, mode, output-clamp source) |
| cfg_aux | input | 8 | Auxiliary control word (bit 0: blanking inversion) |
| clamp_pulse | output | 1 | Clamp gating pulse |
| blank_pos | output | 1 | Positive-true blanking signal |
| out_clamp_sel | output | 1 | Output-clamp source selection |

## Verification
Each configuration is tried on full 160-cycle lines. The sync is 10 cycles wide and the blanking window is 25 cycles wide; the two windows start at different points in the line. Because of this, the start cycle of the pulse shows which source and which edge fired, and its length shows which width code applied. The same timing is repeated with active-low sync and with an inverted blanking line. This separates correct polarity handling from a design that simply triggers on the raw level. Lines with two sync pulses 20 cycles apart show whether a retrigger extends the pulse or is dropped. Direct-mode lines with all width and edge bits set show that the pulse shape then comes only from the input.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

    typedef enum logic {
        SRC_SYNC  = 1'b0,
        SRC_BLANK = 1'b1
    } trig_src_e;

    typedef enum logic {
        EDGE_LEAD  = 1'b0,
        EDGE_TRAIL = 1'b1
    } trig_edge_e;

    typedef enum logic {
        MODE_GEN    = 1'b0,
        MODE_DIRECT = 1'b1
    } clamp_mode_e;

    typedef struct packed {
        logic        oc_src;
        clamp_mode_e mode;
        logic [1:0]  width_code;
        trig_edge_e  edge_sel;
        trig_src_e   src;
        logic        blank_inv;
    } cfg_t;

    // Pulse length in clock cycles for a width code.
    function automatic int pulse_cycles(input int base, input logic [1:0] code);
        return base << code;
    endfunction

endpackage

// File: rtl/cpg_sync.sv
module cpg_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= d;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cpg_polarity.sv
module cpg_polarity #(
    parameter int CNT_W = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic active_low
);
    logic             level_d;
    logic [CNT_W-1:0] hi_cnt;
    logic [CNT_W-1:0] lo_cnt;
    logic             line_start;

    assign line_start = level & ~level_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_d    <= 1'b0;
            hi_cnt     <= '0;
            lo_cnt     <= '0;
            active_low <= 1'b0;
        end else begin
            level_d <= level;
            if (line_start) begin
                active_low <= (hi_cnt > lo_cnt);
                hi_cnt     <= CNT_W'(1);
                lo_cnt     <= '0;
            end else if (level) begin
                if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
            end else begin
                if (lo_cnt != '1) lo_cnt <= lo_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cpg_pulse.sv
module cpg_pulse
    import cpg_pkg::*;
#(
    parameter int BASE_WIDTH = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       level,
    input  trig_edge_e edge_sel,
    input  logic [1:0] width_code,
    output logic       pulse
);
    localparam int MAX_CYC = BASE_WIDTH * 8;
    localparam int CW      = $clog2(MAX_CYC);

    logic          level_d;
    logic          fire;
    logic [CW-1:0] remain;

    always_comb begin
        if (edge_sel == EDGE_TRAIL) fire = level_d & ~level;
        else                        fire = level & ~level_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_d <= 1'b0;
            remain  <= '0;
            pulse   <= 1'b0;
        end else begin
            level_d <= level;
            if (fire) begin
                pulse  <= 1'b1;
                remain <= CW'(pulse_cycles(BASE_WIDTH, width_code) - 1);
            end else if (remain != '0) begin
                remain <= remain - 1'b1;
            end else begin
                pulse <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen
    import cpg_pkg::*;
#(
    parameter int BASE_WIDTH  = 8,
    parameter int LINE_CNT_W  = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hsync_in,
    input  logic       blank_in,
    input  logic [7:0] cfg_main,
    input  logic [7:0] cfg_aux,
    output logic       clamp_pulse,
    output logic       blank_pos,
    output logic       out_clamp_sel
);
    cfg_t       cfg;
    logic       cfg_unused;
    logic [1:0] raw_in;
    logic [1:0] synced;
    logic       hs_s;
    logic       bk_s;
    logic       hs_low;
    logic       hs_pos;
    logic       trig_level;
    logic       gen_pulse;

    assign cfg.src        = trig_src_e'(cfg_main[0]);
    assign cfg.edge_sel   = trig_edge_e'(cfg_main[1]);
    assign cfg.width_code = cfg_main[3:2];
    assign cfg.mode       = clamp_mode_e'(cfg_main[4]);
    assign cfg.oc_src     = cfg_main[7];
    assign cfg.blank_inv  = cfg_aux[0];
    assign cfg_unused     = ^{cfg_main[6:5], cfg_aux[7:1]};

    assign raw_in = {blank_in, hsync_in};

    cpg_sync #(
        .WIDTH (2),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (raw_in),
        .q  (synced)
    );

    assign hs_s = synced[0];
    assign bk_s = synced[1];

    cpg_polarity #(
        .CNT_W(LINE_CNT_W)
    ) u_polarity (
        .clk       (clk),
        .rst       (rst),
        .level     (hs_s),
        .active_low(hs_low)
    );

    assign hs_pos    = hs_s ^ hs_low;
    assign blank_pos = bk_s ^ cfg.blank_inv;

    always_comb begin
        if (cfg.src == SRC_BLANK) trig_level = blank_pos;
        else                      trig_level = hs_pos;
    end

    cpg_pulse #(
        .BASE_WIDTH(BASE_WIDTH)
    ) u_pulse (
        .clk       (clk),
        .rst       (rst),
        .level     (trig_level),
        .edge_sel  (cfg.edge_sel),
        .width_code(cfg.width_code),
        .pulse     (gen_pulse)
    );

    always_comb begin
        if (cfg.mode == MODE_DIRECT) clamp_pulse = hs_s;
        else                         clamp_pulse = gen_pulse;
    end

    assign out_clamp_sel = cfg.oc_src;
endmodule

// File: rtl/cpg_checks.sv
module cpg_checks #(
    parameter int BASE_WIDTH = 8
) (
    input logic       clk,
    input logic       rst,
    input logic       hsync_in,
    input logic       blank_in,
    input logic [7:0] cfg_main,
    input logic [7:0] cfg_aux,
    input logic       clamp_pulse,
    input logic       blank_pos,
    input logic       out_clamp_sel
);
    logic [1:0] run_age;
    logic       past_ok;
    logic [7:0] hi_run;
    logic [7:0] cfg_age;
    logic [7:0] cfg_prev;
    logic       unused_chk;

    assign unused_chk = out_clamp_sel;
    assign past_ok    = (run_age == 2'd3);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_age  <= '0;
            hi_run   <= '0;
            cfg_age  <= '0;
            cfg_prev <= cfg_main;
        end else begin
            if (run_age != 2'd3) run_age <= run_age + 1'b1;
            if (clamp_pulse) begin
                if (hi_run != 8'hFF) hi_run <= hi_run + 1'b1;
            end else begin
                hi_run <= '0;
            end
            cfg_prev <= cfg_main;
            if (cfg_main != cfg_prev)  cfg_age <= '0;
            else if (cfg_age != 8'hFF) cfg_age <= cfg_age + 1'b1;
        end
    end

    // R1: idle outputs right after reset
    a_r1_reset_idle: assert property (@(posedge clk)
        $past(rst) |-> (!clamp_pulse && (blank_pos == cfg_aux[0])));

    // R7: blanking output is the delayed input with optional inversion
    a_r7_blank_path: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (blank_pos == ($past(blank_in, 2) ^ cfg_aux[0])));

    // R8: direct mode follows the raw sync two edges later
    a_r8_direct_follow: assert property (@(posedge clk) disable iff (rst)
        (past_ok && cfg_main[4]) |-> (clamp_pulse == $past(hsync_in, 2)));

    // R5: a generated pulse never ends before its programmed width
    a_r5_min_width: assert property (@(posedge clk) disable iff (rst)
        ($fell(clamp_pulse) && !cfg_main[4] && (int'(cfg_age) > int'(hi_run) + 4))
        |-> (int'(hi_run) >= (BASE_WIDTH << cfg_main[3:2])));
endmodule

bind clamp_pulse_gen cpg_checks u_cpg_checks (
    .clk          (clk),
    .rst          (rst),
    .hsync_in     (hsync_in),
    .blank_in     (blank_in),
    .cfg_main     (cfg_main),
    .cfg_aux      (cfg_aux),
    .clamp_pulse  (clamp_pulse),
    .blank_pos    (blank_pos),
    .out_clamp_sel(out_clamp_sel)
);

// File: tb/test_clamp_pulse_gen.sv
module test_clamp_pulse_gen;
    logic       clk = 1'b0;
    logic       rst;
    logic       hsync_in;
    logic       blank_in;
    logic [7:0] cfg_main;
    logic [7:0] cfg_aux;
    logic       clamp_pulse;
    logic       blank_pos;
    logic       out_clamp_sel;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    clamp_pulse_gen i_clamp_pulse_gen (
        .clk          (clk),
        .rst          (rst),
        .hsync_in     (hsync_in),
        .blank_in     (blank_in),
        .cfg_main     (cfg_main),
        .cfg_aux      (cfg_aux),
        .clamp_pulse  (clamp_pulse),
        .blank_pos    (blank_pos),
        .out_clamp_sel(out_clamp_sel)
    );

    typedef struct packed {
        logic [7:0] cm;
        logic [7:0] ca;
        logic       hs_neg;
        logic       bk_neg;
        logic [7:0] exp_start;
        logic [7:0] exp_len;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{8'h00, 8'h00, 1'b0, 1'b0, 8'd22, 8'd8 },
        '{8'h06, 8'h00, 1'b0, 1'b0, 8'd32, 8'd16},
        '{8'h08, 8'h00, 1'b1, 1'b0, 8'd22, 8'd32},
        '{8'h0E, 8'h00, 1'b1, 1'b0, 8'd32, 8'd64},
        '{8'h01, 8'h00, 1'b0, 1'b0, 8'd17, 8'd8 },
        '{8'h0B, 8'h00, 1'b0, 1'b0, 8'd42, 8'd32},
        '{8'h05, 8'h01, 1'b0, 1'b1, 8'd17, 8'd16},
        '{8'h0F, 8'h01, 1'b0, 1'b1, 8'd42, 8'd64},
        '{8'h10, 8'h00, 1'b0, 1'b0, 8'd21, 8'd10},
        '{8'h1E, 8'h00, 1'b0, 1'b0, 8'd21, 8'd10}
    };

    localparam int LINE = 160;

    function automatic string row_tag(input int i);
        case (i)
            0:       return "R1 R2 R4 R5";
            1:       return "R2 R4 R5";
            2, 3:    return "R3 R4 R5";
            4, 5:    return "R2 R4 R5";
            6, 7:    return "R7 R2 R4 R5";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One line: sync windows [h0,h1) and [h2,h3), blanking window [15,40).
    task automatic run_line(input int h0, input int h1, input int h2, input int h3,
                            input logic hneg, input logic bneg,
                            output int cf, output int cn, output int bf, output int bn);
        cf = -1; cn = 0; bf = -1; bn = 0;
        for (int idx = 0; idx < LINE; idx++) begin
            hsync_in = ((idx >= h0 && idx < h1) || (idx >= h2 && idx < h3)) ^ hneg;
            blank_in = (idx >= 15 && idx < 40) ^ bneg;
            @(posedge clk);
            @(negedge clk);
            if (clamp_pulse) begin
                cn++;
                if (cf < 0) cf = idx;
            end
            if (blank_pos) begin
                bn++;
                if (bf < 0) bf = idx;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int cf, cn, bf, bn;
        rst = 1'b1; hsync_in = 1'b0; blank_in = 1'b0;
        cfg_main = 8'h00; cfg_aux = 8'h00;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: outputs idle during reset
        check("R1", "clamp_pulse in reset", int'(clamp_pulse), 0);
        check("R1", "blank_pos in reset", int'(blank_pos), 0);
        check("R1", "out_clamp_sel in reset", int'(out_clamp_sel), 0);
        rst = 1'b0;

        for (int v = 0; v < NVEC; v++) begin
            cfg_main = VECS[v].cm;
            cfg_aux  = VECS[v].ca;
            for (int s = 0; s < 3; s++)
                run_line(20, 30, 0, 0, VECS[v].hs_neg, VECS[v].bk_neg, cf, cn, bf, bn);
            run_line(20, 30, 0, 0, VECS[v].hs_neg, VECS[v].bk_neg, cf, cn, bf, bn);
            check(row_tag(v), $sformatf("row %0d pulse start", v), cf, int'(VECS[v].exp_start));
            check(row_tag(v), $sformatf("row %0d pulse length", v), cn, int'(VECS[v].exp_len));
            check("R7", $sformatf("row %0d blank start", v), bf, 16);
            check("R7", $sformatf("row %0d blank length", v), bn, 25);
        end

        // R6: second sync edge 20 cycles into a 64-cycle pulse extends it
        cfg_main = 8'h0C; cfg_aux = 8'h00;
        for (int s = 0; s < 3; s++)
            run_line(20, 25, 40, 45, 1'b0, 1'b0, cf, cn, bf, bn);
        run_line(20, 25, 40, 45, 1'b0, 1'b0, cf, cn, bf, bn);
        check("R6", "retrigger start", cf, 22);
        check("R6", "retrigger length", cn, 84);

        // R7: inversion with a positive raw line gives the complement
        cfg_main = 8'h00; cfg_aux = 8'h01;
        run_line(20, 30, 0, 0, 1'b0, 1'b0, cf, cn, bf, bn);
        check("R7", "inverted blank length", bn, LINE - 25);

        // R9: output-clamp source bit passes through
        cfg_main = 8'h80; cfg_aux = 8'h00;
        @(negedge clk);
        check("R9", "out_clamp_sel set", int'(out_clamp_sel), 1);
        cfg_main = 8'h7F;
        @(negedge clk);
        check("R9", "out_clamp_sel clear", int'(out_clamp_sel), 0);

        // R1: synchronous reset clears an active pulse
        cfg_main = 8'h0C;
        hsync_in = 1'b0;
        repeat (3) @(negedge clk);
        hsync_in = 1'b1;
        repeat (4) @(negedge clk);
        check("R1", "pulse active before reset", int'(clamp_pulse), 1);
        rst = 1'b1;
        @(negedge clk);
        check("R1", "pulse cleared by reset", int'(clamp_pulse), 0);
        rst = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule